// File: doc/BRIEF.md
# Symbol Error Correction Applier

After a Reed-Solomon decoder has located the faulty 9-bit symbols of a 512-byte block, this block patches the block in place. It latches an error count and four records. Each record holds a 1-based symbol index and a 9-bit flip mask. The block turns each index into a byte address and a bit offset. It then XORs the shifted mask into one or two bytes of a byte-wide buffer RAM, using read-modify-write sequences on a single RAM port.

Control is a plain start/busy/done handshake. A one-cycle `start` while the block is idle captures the count and every record, so the inputs may change on the next cycle. `start` is ignored while `busy` is high. There is no streaming interface and no back-pressure. The RAM port is the only path to the data, and the RAM must return read data exactly one cycle after a read request.

Top module: `sym_fix_engine`

## Requirements
- R1: After reset `busy`, `done` and `ram_en` are low, and the RAM is never accessed while `busy` is low.
- R2: `start` sampled while idle captures `err_cnt`, `err_idx` and `err_msk`. `busy` is high from the next cycle until the `done` cycle inclusive. Input changes and `start` pulses while busy have no effect.
- R3: A count of 0 or any count above 4 raises `done` in the cycle after `start` and performs no RAM access.
- R4: For a count n of 1 to 4, records n-1 down to 0 are applied in that order. Record k occupies bits [k*10 +: 10] of `err_idx` and [k*9 +: 9] of `err_msk`.
- R5: A raw index i is 1-based. With d = i-1, the byte address is d + (d >> 3) and the bit offset is d & 7. A raw index of 0 is skipped.
- R6: The mask is shifted left by the offset. Bits [7:0] of the result are XORed into the byte at the address and bits [15:8] into the byte at address+1.
- R7: A record whose byte address is 512 or more makes no RAM access.
- R8: When the byte address is exactly 511, only that byte is updated.
- R9: Each byte update is a read followed in the next cycle by a write to the same address, with the write data equal to the returned byte XOR the mask part.
- R10: `done` is a one-cycle pulse in the cycle after the last write (or skip), and `busy` is low in the cycle after `done`.
- R11: Corrections that touch the same byte accumulate, because each later update reads the result of the earlier write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a correction pass (idle only) |
| err_cnt | input | 4 | Number of valid records |
| err_idx | input | 40 | Four 10-bit 1-based symbol indices |
| err_msk | input | 36 | Four 9-bit flip masks |
| busy | output | 1 | Pass in progress |
| done | output | 1 | One-cycle completion pulse |
| ram_en | output | 1 | RAM access request |
| ram_we | output | 1 | 1 = write, 0 = read |
| ram_addr | output | 9 | RAM byte address |
| ram_wdata | output | 8 | RAM write data |
| ram_rdata | input | 8 | RAM read data, one cycle after a read |

## Verification
The hardest cases to reach are the ones at the edges of the buffer. One is the index whose address lands exactly on byte 511, which drops the upper half of the mask. Another is the neighbouring indices that fall past the end of the buffer and must cause no access at all. The stimulus table places the indices 456 and 457 directly, and adds a straddle at a byte boundary and a raw index of zero. For each pass the bench records the address of every write, so the order of records and the absence of stray writes are compared, not only the final buffer contents. Two passes point several records at the same bytes to show that updates accumulate.

// File: rtl/sfx_pkg.sv
package sfx_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_MAP,
    ST_RD_LO,
    ST_WR_LO,
    ST_RD_HI,
    ST_WR_HI,
    ST_FIN
  } sfx_state_e;

  localparam int BYTE_W = 8;
  localparam int SHIFT_W = 16;
endpackage

// File: rtl/sfx_rec_sel.sv
module sfx_rec_sel #(
  parameter int N_REC = 4,
  parameter int IDX_W = 10,
  parameter int MSK_W = 9,
  localparam int PTR_W = (N_REC > 1) ? $clog2(N_REC) : 1
) (
  input  logic [N_REC*IDX_W-1:0] idx_flat,
  input  logic [N_REC*MSK_W-1:0] msk_flat,
  input  logic [PTR_W-1:0]       sel,
  output logic [IDX_W-1:0]       idx_o,
  output logic [MSK_W-1:0]       msk_o
);
  logic [IDX_W-1:0] idx_arr [N_REC];
  logic [MSK_W-1:0] msk_arr [N_REC];

  for (genvar g = 0; g < N_REC; g++) begin : g_unpack
    assign idx_arr[g] = idx_flat[g*IDX_W +: IDX_W];
    assign msk_arr[g] = msk_flat[g*MSK_W +: MSK_W];
  end

  assign idx_o = idx_arr[sel];
  assign msk_o = msk_arr[sel];
endmodule

// File: rtl/sfx_sym_map.sv
module sfx_sym_map
  import sfx_pkg::*;
#(
  parameter int IDX_W = 10,
  parameter int MSK_W = 9,
  parameter int DEPTH = 512,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic [IDX_W-1:0]  idx,
  input  logic [MSK_W-1:0]  msk,
  output logic [AW-1:0]     addr,
  output logic [BYTE_W-1:0] lo_bits,
  output logic [BYTE_W-1:0] hi_bits,
  output logic              hit,
  output logic              pair
);
  logic [IDX_W-1:0]   d;
  logic [IDX_W:0]     wide;
  logic [SHIFT_W-1:0] shifted;

  // zero-based symbol number
  assign d = idx - IDX_W'(1);
  // one extra byte for every eight symbols of 9 bits
  assign wide = {1'b0, d} + {4'b0, d[IDX_W-1:3]};
  assign hit  = (idx != '0) && (wide < (IDX_W+1)'(DEPTH));
  assign pair = wide < (IDX_W+1)'(DEPTH - 1);
  assign addr = wide[AW-1:0];

  assign shifted = {{(SHIFT_W-MSK_W){1'b0}}, msk} << d[2:0];
  assign lo_bits = shifted[7:0];
  assign hi_bits = shifted[15:8];
endmodule

// File: rtl/sym_fix_engine.sv
module sym_fix_engine
  import sfx_pkg::*;
#(
  parameter int N_REC = 4,
  parameter int CNT_W = 4,
  parameter int IDX_W = 10,
  parameter int MSK_W = 9,
  parameter int DEPTH = 512,
  localparam int AW    = $clog2(DEPTH),
  localparam int PTR_W = (N_REC > 1) ? $clog2(N_REC) : 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   start,
  input  logic [CNT_W-1:0]       err_cnt,
  input  logic [N_REC*IDX_W-1:0] err_idx,
  input  logic [N_REC*MSK_W-1:0] err_msk,
  output logic                   busy,
  output logic                   done,
  output logic                   ram_en,
  output logic                   ram_we,
  output logic [AW-1:0]          ram_addr,
  output logic [BYTE_W-1:0]      ram_wdata,
  input  logic [BYTE_W-1:0]      ram_rdata
);
  sfx_state_e st;
  logic [PTR_W-1:0]       ptr;
  logic [N_REC*IDX_W-1:0] idx_q;
  logic [N_REC*MSK_W-1:0] msk_q;
  logic [AW-1:0]          addr_q;
  logic [BYTE_W-1:0]      lo_q, hi_q;
  logic                   pair_q;

  logic [IDX_W-1:0]  cur_idx;
  logic [MSK_W-1:0]  cur_msk;
  logic [AW-1:0]     m_addr;
  logic [BYTE_W-1:0] m_lo, m_hi;
  logic              m_hit, m_pair;
  logic              cnt_ok;
  logic              last_rec;

  sfx_rec_sel #(.N_REC(N_REC), .IDX_W(IDX_W), .MSK_W(MSK_W)) u_sel (
    .idx_flat(idx_q), .msk_flat(msk_q), .sel(ptr),
    .idx_o(cur_idx), .msk_o(cur_msk)
  );

  sfx_sym_map #(.IDX_W(IDX_W), .MSK_W(MSK_W), .DEPTH(DEPTH)) u_map (
    .idx(cur_idx), .msk(cur_msk),
    .addr(m_addr), .lo_bits(m_lo), .hi_bits(m_hi),
    .hit(m_hit), .pair(m_pair)
  );

  assign cnt_ok   = (err_cnt != '0) && (err_cnt <= CNT_W'(N_REC));
  assign last_rec = (ptr == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= ST_IDLE;
      ptr    <= '0;
      idx_q  <= '0;
      msk_q  <= '0;
      addr_q <= '0;
      lo_q   <= '0;
      hi_q   <= '0;
      pair_q <= 1'b0;
    end else begin
      case (st)
        ST_IDLE: if (start) begin
          idx_q <= err_idx;
          msk_q <= err_msk;
          if (cnt_ok) begin
            ptr <= PTR_W'(err_cnt - CNT_W'(1));
            st  <= ST_MAP;
          end else begin
            st  <= ST_FIN;
          end
        end
        ST_MAP: begin
          if (m_hit) begin
            addr_q <= m_addr;
            lo_q   <= m_lo;
            hi_q   <= m_hi;
            pair_q <= m_pair;
            st     <= ST_RD_LO;
          end else if (last_rec) begin
            st <= ST_FIN;
          end else begin
            ptr <= ptr - PTR_W'(1);
          end
        end
        ST_RD_LO: st <= ST_WR_LO;
        ST_WR_LO: begin
          if (pair_q) st <= ST_RD_HI;
          else if (last_rec) st <= ST_FIN;
          else begin
            ptr <= ptr - PTR_W'(1);
            st  <= ST_MAP;
          end
        end
        ST_RD_HI: st <= ST_WR_HI;
        ST_WR_HI: begin
          if (last_rec) st <= ST_FIN;
          else begin
            ptr <= ptr - PTR_W'(1);
            st  <= ST_MAP;
          end
        end
        ST_FIN:  st <= ST_IDLE;
        default: st <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    busy      = (st != ST_IDLE);
    done      = (st == ST_FIN);
    ram_en    = (st == ST_RD_LO) || (st == ST_WR_LO) || (st == ST_RD_HI) || (st == ST_WR_HI);
    ram_we    = (st == ST_WR_LO) || (st == ST_WR_HI);
    ram_addr  = ((st == ST_RD_HI) || (st == ST_WR_HI)) ? addr_q + AW'(1) : addr_q;
    ram_wdata = ram_rdata ^ ((st == ST_WR_HI) ? hi_q : lo_q);
  end

  AST_IDLE_NO_RAM: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !ram_en); // R1
  AST_START_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy); // R2
  AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |=> busy); // R2
  AST_BAD_CNT_FIN: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && !cnt_ok) |=> (done && !ram_en)); // R3
  AST_WRITE_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (ram_en && ram_we) |-> ($past(ram_en && !ram_we) && ram_addr == $past(ram_addr))); // R9
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && !busy)); // R10
endmodule

// File: tb/sym_fix_engine_test.sv
module sym_fix_engine_test;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 8;
  localparam int DEPTH = 512;

  // count, then records 0..3 as index and mask
  localparam int V_CNT [NV] = '{1, 4, 2, 5, 0, 3, 3, 4};
  localparam int V_IDX [NV][4] = '{
    '{1, 0, 0, 0},
    '{10, 100, 300, 500},
    '{8, 456, 50, 60},
    '{3, 4, 5, 6},
    '{7, 8, 9, 10},
    '{0, 457, 20, 33},
    '{5, 5, 6, 0},
    '{456, 455, 1, 2}
  };
  localparam int V_MSK [NV][4] = '{
    '{'h1FF, 0, 0, 0},
    '{'h001, 'h155, 'h0AA, 'h1FF},
    '{'h1FF, 'h1FF, 'h0F0, 'h00F},
    '{'h1FF, 'h1FF, 'h1FF, 'h1FF},
    '{'h1FF, 'h1FF, 'h1FF, 'h1FF},
    '{'h1FF, 'h1FF, 'h123, 'h055},
    '{'h003, 'h003, 'h100, 0},
    '{'h1FF, 'h101, 'h0C3, 'h1FF}
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic [3:0] err_cnt = '0;
  logic [39:0] err_idx = '0;
  logic [35:0] err_msk = '0;
  logic       busy, done, ram_en, ram_we;
  logic [8:0] ram_addr;
  logic [7:0] ram_wdata;
  logic [7:0] ram_rdata;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  logic [7:0] mem  [DEPTH];
  logic [7:0] gold [DEPTH];
  int wlog [1024];
  int wlog_n = 0;
  int exp_list [64];
  int exp_n;

  always #(CLK_PERIOD/2) clk = ~clk;

  sym_fix_engine uut (
    .clk(clk), .rst_n(rst_n), .start(start), .err_cnt(err_cnt),
    .err_idx(err_idx), .err_msk(err_msk), .busy(busy), .done(done),
    .ram_en(ram_en), .ram_we(ram_we), .ram_addr(ram_addr),
    .ram_wdata(ram_wdata), .ram_rdata(ram_rdata)
  );

  function automatic logic [7:0] fill(int i);
    return 8'((i * 37) ^ 'h5A);
  endfunction

  // byte-wide RAM, one cycle read latency, write log
  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= fill(i);
      ram_rdata <= '0;
    end else if (ram_en) begin
      if (ram_we) begin
        mem[ram_addr] <= ram_wdata;
        wlog[wlog_n] <= int'(ram_addr);
        wlog_n <= wlog_n + 1;
      end else begin
        ram_rdata <= mem[ram_addr];
      end
    end
  end

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      errors = errors + 1;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
      summary();
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // independent model of the required behaviour (R4..R8, R11)
  task automatic model(input int cnt, input int idx[4], input int msk[4]);
    exp_n = 0;
    if (cnt >= 1 && cnt <= 4) begin
      for (int r = cnt - 1; r >= 0; r--) begin
        int d, a, sh;
        if (idx[r] == 0) continue;
        d = idx[r] - 1;
        a = d + d / 8;
        if (a >= DEPTH) continue;
        sh = msk[r] << (d % 8);
        gold[a] = gold[a] ^ 8'(sh);
        exp_list[exp_n] = a; exp_n++;
        if (a < DEPTH - 1) begin
          gold[a+1] = gold[a+1] ^ 8'(sh >> 8);
          exp_list[exp_n] = a + 1; exp_n++;
        end
      end
    end
  endtask

  task automatic drive(input int cnt, input int idx[4], input int msk[4]);
    err_cnt = 4'(cnt);
    for (int r = 0; r < 4; r++) begin
      err_idx[r*10 +: 10] = 10'(idx[r]);
      err_msk[r*9 +: 9] = 9'(msk[r]);
    end
  endtask

  // one pass; disturb pulses start and scrambles inputs while busy
  task automatic run(input int cnt, input int idx[4], input int msk[4],
                     input bit disturb, input string tag);
    int base, n_done, waited, mism, first_bad;
    bit order_ok;
    base = wlog_n;
    model(cnt, idx, msk);
    @(negedge clk);
    drive(cnt, idx, msk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy == 1'b1, {tag, " R2 busy after start"}, int'(busy), 1);
    n_done = 0;
    waited = 0;
    while (!done && waited < 200) begin
      if (disturb && waited == 2) begin
        err_cnt = 4'd4;
        err_idx = {4{10'd3}};
        err_msk = {4{9'h1FF}};
        start = 1'b1;
      end else begin
        start = 1'b0;
      end
      @(negedge clk);
      waited++;
    end
    start = 1'b0;
    if (done) n_done++;
    @(negedge clk);
    if (done) n_done++;
    chk(n_done == 1, {tag, " R10 done pulse count"}, n_done, 1);
    chk(busy == 1'b0, {tag, " R10 busy low after done"}, int'(busy), 0);
    chk(wlog_n - base == exp_n, {tag, " R4/R7 write count"}, wlog_n - base, exp_n);
    order_ok = 1'b1;
    for (int k = 0; k < exp_n && k < wlog_n - base; k++)
      if (wlog[base + k] != exp_list[k]) order_ok = 1'b0;
    chk(order_ok, {tag, " R4 R8 write address order"}, int'(order_ok), 1);
    mism = 0;
    first_bad = -1;
    for (int i = 0; i < DEPTH; i++)
      if (mem[i] !== gold[i]) begin
        mism++;
        if (first_bad < 0) first_bad = i;
      end
    chk(mism == 0, {tag, " R6 R9 R11 buffer contents (mismatch count)"}, mism, 0);
    if (mism != 0)
      $display("  first bad byte %0d: actual %0d expected %0d",
               first_bad, mem[first_bad], gold[first_bad]);
  endtask

  initial begin
    for (int i = 0; i < DEPTH; i++) gold[i] = fill(i);
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(busy == 1'b0, "R1 busy in reset", int'(busy), 0);
    chk(done == 1'b0, "R1 done in reset", int'(done), 0);
    chk(ram_en == 1'b0, "R1 ram_en in reset", int'(ram_en), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(busy == 1'b0 && ram_en == 1'b0, "R1 idle after reset", int'(busy), 0);

    // table walk: R3 (counts 5 and 0), R5 zero index, R7/R8 buffer end, R11 overlap
    for (int v = 0; v < NV; v++) begin
      int ci[4], cm[4];
      for (int r = 0; r < 4; r++) begin ci[r] = V_IDX[v][r]; cm[r] = V_MSK[v][r]; end
      run(V_CNT[v], ci, cm, 1'b0, $sformatf("vec%0d", v));
    end

    // R3 timing: bad count gives done in the very next cycle, no RAM access
    begin
      int ci[4] = '{1, 2, 3, 4};
      int cm[4] = '{'h1FF, 'h1FF, 'h1FF, 'h1FF};
      int base;
      base = wlog_n;
      @(negedge clk);
      drive(9, ci, cm);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      chk(done == 1'b1, "R3 done one cycle after bad count", int'(done), 1);
      chk(ram_en == 1'b0, "R3 no RAM access on bad count", int'(ram_en), 0);
      @(negedge clk);
      chk(wlog_n == base, "R3 no writes on bad count", wlog_n - base, 0);
    end

    // R2: inputs changed and start pulsed while busy have no effect
    begin
      int ci[4] = '{200, 201, 202, 203};
      int cm[4] = '{'h0F0, 'h10F, 'h0AA, 'h055};
      run(4, ci, cm, 1'b1, "R2 disturb");
    end

    // R5 straddle: index 8 spans bytes 7 and 8 after reload of fresh values
    begin
      int ci[4] = '{8, 0, 0, 0};
      int cm[4] = '{'h1FF, 0, 0, 0};
      run(1, ci, cm, 1'b0, "R5 straddle");
    end

    repeat (2) @(negedge clk);
    summary();
  end
endmodule